// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block holds the single reservation of one hart's load-reserved / store-conditional pair. A load-reserved command records the cache-line address and a byte mask within that line. The mask covers at least the aligned granule around the access: 4 bytes by default, or more if the access is wider.

While the reservation is held, the block watches snoop requests from other agents. If a request grants write permission and touches any reserved byte, the reservation is marked as broken. A cacheable snoop is taken to cover its whole line. A non-cacheable write covers only its own sized, aligned bytes. A later store-conditional gets a result code one cycle after it is issued. Code 0 means the store may be written. Any nonzero code means it fails and must not write.

The control is a three-state machine:
- **ST_IDLE**: no reservation is held.
- **ST_HELD**: a clean reservation is held.
- **ST_BROKEN**: a reservation is held but has seen interference.

The transitions are:
- **ARM**: a load-reserved from any state goes to ST_HELD.
- **DROP**: a store-conditional from any state goes to ST_IDLE.
- **SPOIL**: a write-permission snoop that overlaps the reserved bytes goes from ST_HELD to ST_BROKEN.
- **KEEP**: when none of the above applies, the state stays where it is.

If a load-reserved and a store-conditional could both apply, ARM wins. If a store-conditional and a snoop arrive in the same cycle, DROP wins.

Top module: `rsv_monitor`

## Requirements
- R1: After reset no reservation is held and `sc_valid` is low.
- R2: A load-reserved reserves the aligned block of max(4, 2^size) bytes containing its address, within its 64-byte line. Sizes are encoded as log2 of the byte count (0..3), and addresses are aligned down to the access size.
- R3: A store-conditional produces exactly one cycle of `sc_valid`, in the cycle after it is issued. When the reservation is clean and covers all of the store's bytes, the code is 0 (pass). `sc_valid` is never high at any other time.
- R4: A store-conditional to a different line, or with bytes outside the reserved mask, returns code 2 (outside) when the reservation is otherwise clean.
- R5: A cacheable snoop with write permission to the reserved line breaks the reservation, whatever its offset. A later store-conditional then returns code 1 (lost). Snoops to other lines have no effect.
- R6: A non-cacheable write snoop breaks the reservation only if its sized bytes overlap the reserved bytes. A disjoint write in the same line has no effect.
- R7: A snoop without write permission (a plain read) never breaks the reservation.
- R8: Every store-conditional clears the reservation, whether it passes or fails. A second store-conditional without a new load-reserved returns code 1.
- R9: A new load-reserved replaces any existing reservation and its broken mark.
- R10: A snoop that would break the reservation, arriving in the same cycle as a store-conditional, makes that store-conditional return code 1.
- R11: A store-conditional with no reservation held returns code 1.
- R12: A snoop arriving in the same cycle as a load-reserved does not affect the new reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A reserved-access command is present |
| cmd_is_sc | input | 1 | 1 = store-conditional, 0 = load-reserved |
| cmd_addr | input | ADDR_W | Byte address of the command |
| cmd_size | input | 2 | log2 of the access size in bytes |
| snp_valid | input | 1 | A snoop request is present |
| snp_addr | input | ADDR_W | Byte address of the snoop |
| snp_cacheable | input | 1 | 1 = whole-line request, 0 = sized non-cacheable request |
| snp_size | input | 2 | log2 of the non-cacheable access size |
| snp_wperm | input | 1 | The request grants write permission to its requester |
| sc_valid | output | 1 | Store-conditional result is present |
| sc_code | output | 2 | 0 pass, 1 lost, 2 outside the reservation |

## Verification
The hardest situations to reach from the ports are the ones where a snoop coincides with a command. The first is a snoop that overlaps the reserved bytes in the very cycle a store-conditional is issued. The second is a snoop that overlaps in the very cycle a new load-reserved replaces the old reservation.

Directed steps force both coincidences at fixed addresses. Directed steps also cover a non-cacheable write that lands one byte inside the reserved granule, and one that lands just beside it. The random phase confines all traffic to two lines, with narrow offsets and sizes. As a result, snoops, reservations and store-conditionals collide in the same line in most cycles, and byte-level overlap is often decided by a single byte.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HELD   = 2'd1,
        ST_BROKEN = 2'd2
    } rsv_state_e;

    localparam logic [1:0] SC_PASS    = 2'd0;
    localparam logic [1:0] SC_LOST    = 2'd1;
    localparam logic [1:0] SC_OUTSIDE = 2'd2;

endpackage

// File: rtl/rsv_span.sv
module rsv_span #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int MIN_LOG2   = 0,
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [1:0]              size_log2,
    input  logic                    whole_line,
    output logic [ADDR_W-OFF_W-1:0] line,
    output logic [LINE_BYTES-1:0]   mask
);
    int             lg;
    int             nbytes;
    logic [OFF_W-1:0] base;

    always_comb begin
        lg     = (int'(size_log2) < MIN_LOG2) ? MIN_LOG2 : int'(size_log2);
        nbytes = 1 << lg;
        base   = addr[OFF_W-1:0] & ~OFF_W'(nbytes - 1);
    end

    assign line = addr[ADDR_W-1:OFF_W];

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        assign mask[b] = whole_line || ((b >= int'(base)) && (b < int'(base) + nbytes));
    end

endmodule

// File: rtl/rsv_fsm.sv
module rsv_fsm
    import rsv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lr_fire,
    input  logic       sc_fire,
    input  logic       snoop_hit,
    output rsv_state_e state_q
);
    rsv_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (lr_fire) begin
            state_d = ST_HELD;                 // ARM
        end else if (sc_fire) begin
            state_d = ST_IDLE;                 // DROP
        end else begin
            unique case (state_q)
                ST_HELD:   if (snoop_hit) state_d = ST_BROKEN;   // SPOIL
                ST_IDLE,
                ST_BROKEN: state_d = state_q;                    // KEEP
                default:   state_d = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
    import rsv_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int GRAN_LOG2  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_is_sc,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [1:0]        cmd_size,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              snp_cacheable,
    input  logic [1:0]        snp_size,
    input  logic              snp_wperm,
    output logic              sc_valid,
    output logic [1:0]        sc_code
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int LINE_W = ADDR_W - OFF_W;

    rsv_state_e            state_q;
    logic [LINE_W-1:0]     rsv_line_q;
    logic [LINE_BYTES-1:0] rsv_mask_q;

    logic [LINE_W-1:0]     lr_line,  sc_line,  snp_line;
    logic [LINE_BYTES-1:0] lr_mask,  sc_mask,  snp_mask;
    logic                  lr_fire, sc_fire, snoop_hit, sc_inside;
    logic [1:0]            code_d;

    assign lr_fire = cmd_valid && !cmd_is_sc;
    assign sc_fire = cmd_valid &&  cmd_is_sc;

    rsv_span #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MIN_LOG2(GRAN_LOG2)) u_lr_span (
        .addr(cmd_addr), .size_log2(cmd_size), .whole_line(1'b0),
        .line(lr_line), .mask(lr_mask)
    );
    rsv_span #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MIN_LOG2(0)) u_sc_span (
        .addr(cmd_addr), .size_log2(cmd_size), .whole_line(1'b0),
        .line(sc_line), .mask(sc_mask)
    );
    rsv_span #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MIN_LOG2(0)) u_snp_span (
        .addr(snp_addr), .size_log2(snp_size), .whole_line(snp_cacheable),
        .line(snp_line), .mask(snp_mask)
    );

    assign snoop_hit = snp_valid && snp_wperm && (state_q == ST_HELD) &&
                       (snp_line == rsv_line_q) && |(snp_mask & rsv_mask_q);
    assign sc_inside = (sc_line == rsv_line_q) && ((sc_mask & ~rsv_mask_q) == '0);

    rsv_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .lr_fire(lr_fire), .sc_fire(sc_fire), .snoop_hit(snoop_hit),
        .state_q(state_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsv_line_q <= '0;
            rsv_mask_q <= '0;
        end else if (lr_fire) begin
            rsv_line_q <= lr_line;
            rsv_mask_q <= lr_mask;
        end
    end

    always_comb begin
        if ((state_q != ST_HELD) || snoop_hit) code_d = SC_LOST;
        else if (!sc_inside)                   code_d = SC_OUTSIDE;
        else                                   code_d = SC_PASS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_valid <= 1'b0;
            sc_code  <= SC_PASS;
        end else begin
            sc_valid <= sc_fire;
            sc_code  <= sc_fire ? code_d : SC_PASS;
        end
    end

    AST_RESP_AFTER_SC: assert property (@(posedge clk) disable iff (!rst_n)
        sc_fire |=> sc_valid);                                              // R3
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_fire |=> !sc_valid);                                            // R3
    AST_SC_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        sc_fire |=> state_q == ST_IDLE);                                    // R8
    AST_LR_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        lr_fire |=> state_q == ST_HELD);                                    // R9
    AST_NOHOLD_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_fire && state_q != ST_HELD) |=> sc_code == SC_LOST);            // R11
    AST_COLLIDE_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_fire && snoop_hit) |=> sc_code == SC_LOST);                     // R10
    AST_READ_SNOOP_HARMLESS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && !cmd_valid && snp_valid && !snp_wperm)
        |=> state_q == ST_HELD);                                            // R7
    AST_LINE_SNOOP_BREAKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && !cmd_valid && snp_valid && snp_wperm &&
         snp_cacheable && snp_line == rsv_line_q) |=> state_q == ST_BROKEN); // R5

endmodule

// File: tb/test_rsv_monitor.sv
module test_rsv_monitor;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid, cmd_is_sc, snp_valid, snp_cacheable, snp_wperm;
    logic [31:0] cmd_addr, snp_addr;
    logic [1:0]  cmd_size, snp_size;
    logic        sc_valid;
    logic [1:0]  sc_code;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // reference model state
    bit          m_valid, m_broken;
    logic [25:0] m_line;
    logic [63:0] m_mask;
    bit          exp_v;
    int          exp_code;
    string       exp_tag;

    always #10 clk = ~clk;

    rsv_monitor i_rsv_monitor (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_is_sc(cmd_is_sc), .cmd_addr(cmd_addr), .cmd_size(cmd_size),
        .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_cacheable(snp_cacheable),
        .snp_size(snp_size), .snp_wperm(snp_wperm),
        .sc_valid(sc_valid), .sc_code(sc_code)
    );

    function automatic logic [63:0] bmask(input logic [31:0] a, input int lg_in,
                                          input int minlg, input bit whole);
        int lg = (lg_in < minlg) ? minlg : lg_in;
        int n = 1 << lg;
        int base = int'(a[5:0]) & ~(n - 1);
        logic [63:0] m = '0;
        if (whole) return '1;
        for (int b = 0; b < 64; b++) if (b >= base && b < base + n) m[b] = 1'b1;
        return m;
    endfunction

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive one cycle at the falling edge, update the model, check one cycle later
    task automatic cycle(input bit cv, input bit is_sc, input logic [31:0] ca, input int cs,
                         input bit sv, input logic [31:0] sa, input bit scb, input int ss,
                         input bit sw, input string tag);
        bit hit;
        cmd_valid = cv; cmd_is_sc = is_sc; cmd_addr = ca; cmd_size = 2'(cs);
        snp_valid = sv; snp_addr = sa; snp_cacheable = scb; snp_size = 2'(ss); snp_wperm = sw;
        hit = sv && sw && m_valid && !m_broken && (sa[31:6] == m_line) &&
              |(bmask(sa, ss, 0, scb) & m_mask);
        exp_v = 0; exp_code = 0; exp_tag = tag;
        if (cv && is_sc) begin
            exp_v = 1;
            if (!m_valid) begin exp_code = 1; if (tag == "") exp_tag = "R11"; end
            else if (hit) begin exp_code = 1; if (tag == "") exp_tag = "R10"; end
            else if (m_broken) begin exp_code = 1; if (tag == "") exp_tag = "R6"; end
            else if (ca[31:6] != m_line || (bmask(ca, cs, 0, 0) & ~m_mask) != '0) begin
                exp_code = 2; if (tag == "") exp_tag = "R4";
            end else begin exp_code = 0; if (tag == "") exp_tag = "R3"; end
            m_valid = 0; m_broken = 0;
        end else if (cv) begin
            m_valid = 1; m_broken = 0; m_line = ca[31:6]; m_mask = bmask(ca, cs, 2, 0);
            if (tag == "") exp_tag = "R3";
        end else begin
            if (hit) m_broken = 1;
            if (tag == "") exp_tag = "R3";
        end
        @(negedge clk);
        check(sc_valid == exp_v, {exp_tag, " sc_valid"}, int'(sc_valid), int'(exp_v));
        if (exp_v) check(int'(sc_code) == exp_code, {exp_tag, " sc_code"}, int'(sc_code), exp_code);
    endtask

    task automatic idle(input string tag);
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic lr(input logic [31:0] a, input int s, input string tag);
        cycle(1, 0, a, s, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic sc(input logic [31:0] a, input int s, input string tag);
        cycle(1, 1, a, s, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic snoop(input logic [31:0] a, input bit cb, input int s, input bit w, input string tag);
        cycle(0, 0, 0, 0, 1, a, cb, s, w, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        cmd_valid = 0; cmd_is_sc = 0; cmd_addr = 0; cmd_size = 0;
        snp_valid = 0; snp_addr = 0; snp_cacheable = 0; snp_size = 0; snp_wperm = 0;
        m_valid = 0; m_broken = 0; m_line = 0; m_mask = 0;
        repeat (3) @(negedge clk);
        check(sc_valid == 0, "R1 sc_valid in reset", int'(sc_valid), 0);
        rst_n = 1;
        idle("R1");
        sc(32'h1000, 2, "R11");                                   // no reservation after reset
        // R2: 1-byte LR reserves the 4-byte granule
        lr(32'h1004, 0, "R2"); sc(32'h1006, 1, "R2");
        // R6: disjoint non-cacheable write, then overlapping one
        lr(32'h1004, 2, "R6"); snoop(32'h1008, 0, 2, 1, "R6"); sc(32'h1004, 2, "R6");
        lr(32'h1004, 2, "R6"); snoop(32'h1007, 0, 0, 1, "R6"); sc(32'h1004, 2, "R6");
        // R5: cacheable write-permission snoop anywhere in line, and in another line
        lr(32'h1004, 2, "R5"); snoop(32'h1030, 1, 0, 1, "R5"); sc(32'h1004, 2, "R5");
        lr(32'h1004, 2, "R5"); snoop(32'h1044, 1, 0, 1, "R5"); sc(32'h1004, 2, "R5");
        // R7: plain reads are harmless
        lr(32'h1004, 2, "R7"); snoop(32'h1004, 1, 0, 0, "R7"); snoop(32'h1004, 0, 2, 0, "R7");
        sc(32'h1004, 2, "R7");
        // R8: second SC fails
        lr(32'h1010, 3, "R8"); sc(32'h1010, 3, "R8"); sc(32'h1010, 3, "R8");
        // R9: replacement
        lr(32'h1000, 2, "R9"); lr(32'h2000, 2, "R9"); sc(32'h1000, 2, "R9");
        lr(32'h1000, 2, "R9"); snoop(32'h1000, 1, 0, 1, "R9"); lr(32'h1000, 2, "R9");
        sc(32'h1000, 2, "R9");
        // R4: wider than reservation, then cleared
        lr(32'h1004, 2, "R4"); sc(32'h1004, 3, "R4"); sc(32'h1004, 2, "R4");
        // R10: snoop and SC together
        lr(32'h1004, 2, "R10"); cycle(1, 1, 32'h1004, 2, 1, 32'h1005, 0, 0, 1, "R10");
        // R12: snoop and LR together
        cycle(1, 0, 32'h1004, 2, 1, 32'h1004, 1, 0, 1, "R12"); sc(32'h1004, 2, "R12");
        idle("R3");

        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom_range(0, 9));
            logic [31:0] ca = 32'h1000 + $urandom_range(0, 127);
            logic [31:0] sa = 32'h1000 + $urandom_range(0, 127);
            bit sv = ($urandom_range(0, 1) == 1);
            bit cv = (r < 6);
            bit is_sc = (r >= 3);
            cycle(cv, is_sc, ca, int'($urandom_range(0, 3)), sv, sa,
                  ($urandom_range(0, 3) == 0), int'($urandom_range(0, 3)),
                  ($urandom_range(0, 2) != 0), "");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
    end

endmodule